// File: doc/BRIEF.md
# Serial Bus Mode Controller

This block keeps the two-bit operating mode of a serial port that can run either a two-wire addressed bus format or a clocked synchronous serial format. The high mode bit selects master (1) or slave (0). The low bit selects transmit (1) or receive (0). Software writes the mode through a small write port. The write also carries a bit that selects the slave setup delay. Bus events reported as single-cycle pulses by neighbouring units can override the mode written by software.

The block drives three things from the mode: an enable for the transfer clock output, a detector that compares an incoming first byte with the port's own address, and a setup-delay timer. The timer holds off the transmit data path after the port becomes a transmitting slave, and again after each new byte request.

Top module: `sbm_mode_ctrl`

## Requirements
- R1: After reset `mode_o` is 2'b00, `clk_oe_o` is 0, `setup_busy_o` is 0 and `setup_ready_o` is 0.
- R2: `mode_o[1]` is the master bit and `mode_o[0]` is the transmit bit, so 00 is slave receive, 01 slave transmit, 10 master receive and 11 master transmit. A write with `frame_idle_i`=1 shows in `mode_o` on the next cycle.
- R3: An `arb_lost_i` pulse with `fmt_i2c_i`=1 while the master bit is 1 sets the mode to 00 on the next cycle. With the master bit at 0, or with `fmt_i2c_i`=0, the pulse leaves the mode unchanged.
- R4: With `fmt_i2c_i`=1 and mode 00, a `rx_byte_vld_i` pulse sets the transmit bit when `rx_byte_i[7:1]` equals `own_addr_i` and `rx_byte_i[0]` is 1. The pulse has no effect in any other mode, in the other format, or for any other byte value.
- R5: An `overrun_i` pulse with `fmt_i2c_i`=0 while the master bit is 1 sets the mode to 00. With `fmt_i2c_i`=1, or with the master bit at 0, the pulse has no effect.
- R6: `clk_oe_o` is 1 exactly when `fmt_i2c_i`=0 and the master bit is 1.
- R7: When a hardware event (R3, R4, R5) and a write occur in the same cycle, the event's result is taken and the whole write is dropped.
- R8: A write with `frame_idle_i`=0 changes the master bit at once. A change of the transmit bit is held back while `frame_idle_i` stays 0, and is applied on the first cycle with `frame_idle_i`=1.
- R9: One cycle after the mode becomes 01, `setup_busy_o` goes high. It stays high for 10 cycles when the stored delay select is 0, or 20 cycles when it is 1. `setup_ready_o` pulses once, in the last busy cycle.
- R10: A `byte_req_i` pulse in mode 01 reloads the full delay. Leaving mode 01 clears `setup_busy_o` one cycle later, and no ready pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fmt_i2c_i | input | 1 | 1 = two-wire addressed format, 0 = clocked synchronous format |
| wr_en_i | input | 1 | Write strobe for the mode register |
| wr_mst_i | input | 1 | Master bit to write |
| wr_trs_i | input | 1 | Transmit bit to write |
| wr_dly_sel_i | input | 1 | Delay select to write (0 short, 1 long) |
| frame_idle_i | input | 1 | High between frames |
| arb_lost_i | input | 1 | Arbitration loss pulse |
| overrun_i | input | 1 | Receive overrun pulse |
| rx_byte_vld_i | input | 1 | First received byte valid pulse |
| rx_byte_i | input | 8 | First received byte (address in [7:1], direction in [0]) |
| own_addr_i | input | 7 | Programmed own address |
| byte_req_i | input | 1 | New transmit byte request pulse |
| mode_o | output | 2 | Current mode {master, transmit} |
| clk_oe_o | output | 1 | Transfer clock output enable |
| setup_busy_o | output | 1 | Setup delay running |
| setup_ready_o | output | 1 | One-cycle pulse when the setup delay ends |

## Verification
Each of the three override pulses is applied in every one of the four modes, under both formats. This separates events that must act from the same pulse arriving in a mode or format where it must be ignored. All 256 values of the first received byte are swept against one fixed own address. Only one value may turn the port into a transmitting slave, so a wrong bit position, a missed direction bit, or a compare that ignores the address shows as a mismatch. The delay timer is measured with both select values and with a mid-count byte request. This tells the 10- and 20-cycle lengths apart and checks that a request reloads the count. Writes made during a frame and a write that collides with an event check the deferral and priority rules.

// File: rtl/sbm_pkg.sv
package sbm_pkg;
    typedef enum logic [1:0] {
        MODE_SRX = 2'b00,
        MODE_STX = 2'b01,
        MODE_MRX = 2'b10,
        MODE_MTX = 2'b11
    } sbm_mode_e;

    typedef struct packed {
        logic mst;
        logic trs;
        logic pend;
        logic pend_val;
        logic dly_sel;
    } sbm_mode_st_t;
endpackage

// File: rtl/sbm_addr_match.sv
module sbm_addr_match #(
    parameter int ADDR_W = 7
) (
    input  logic              fmt_i2c_i,
    input  logic [1:0]        mode_i,
    input  logic              vld_i,
    input  logic [ADDR_W:0]   byte_i,
    input  logic [ADDR_W-1:0] own_addr_i,
    output logic              hit_o
);
    import sbm_pkg::*;

    logic addr_eq;
    logic rd_dir;

    always_comb begin
        addr_eq = (byte_i[ADDR_W:1] == own_addr_i);
        rd_dir  = byte_i[0];
        hit_o   = vld_i && fmt_i2c_i && (mode_i == MODE_SRX) && addr_eq && rd_dir;
    end
endmodule

// File: rtl/sbm_mode_reg.sv
module sbm_mode_reg (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fmt_i2c_i,
    input  logic       wr_en_i,
    input  logic       wr_mst_i,
    input  logic       wr_trs_i,
    input  logic       wr_dly_sel_i,
    input  logic       frame_idle_i,
    input  logic       arb_lost_i,
    input  logic       overrun_i,
    input  logic       addr_hit_i,
    output logic [1:0] mode_o,
    output logic       dly_sel_o
);
    import sbm_pkg::*;

    sbm_mode_st_t st_d, st_q;
    logic arb_evt, ovr_evt, hw_evt;

    always_comb begin
        arb_evt = arb_lost_i && fmt_i2c_i && st_q.mst;
        ovr_evt = overrun_i && !fmt_i2c_i && st_q.mst;
        hw_evt  = arb_evt || ovr_evt || addr_hit_i;
        st_d    = st_q;
        if (arb_evt || ovr_evt) begin
            st_d.mst  = 1'b0;
            st_d.trs  = 1'b0;
            st_d.pend = 1'b0;
        end else if (addr_hit_i) begin
            st_d.trs  = 1'b1;
            st_d.pend = 1'b0;
        end else if (wr_en_i) begin
            st_d.mst     = wr_mst_i;
            st_d.dly_sel = wr_dly_sel_i;
            if (wr_trs_i == st_q.trs) begin
                st_d.pend = 1'b0;
            end else if (frame_idle_i) begin
                st_d.trs  = wr_trs_i;
                st_d.pend = 1'b0;
            end else begin
                st_d.pend     = 1'b1;
                st_d.pend_val = wr_trs_i;
            end
        end else if (st_q.pend && frame_idle_i) begin
            st_d.trs  = st_q.pend_val;
            st_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_o    = {st_q.mst, st_q.trs};
    assign dly_sel_o = st_q.dly_sel;

    a_r3_arb_to_srx: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_lost_i && fmt_i2c_i && mode_o[1]) |=> (mode_o == MODE_SRX));

    a_r5_ovr_to_srx: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun_i && !fmt_i2c_i && mode_o[1]) |=> (mode_o == MODE_SRX));

    a_r4_hit_sets_trs: assert property (@(posedge clk) disable iff (!rst_n)
        addr_hit_i |=> (mode_o == MODE_STX));

    a_r8_trs_held_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_idle_i && !hw_evt) |=> $stable(mode_o[0]));
endmodule

// File: rtl/sbm_setup_timer.sv
module sbm_setup_timer #(
    parameter int SHORT_CYC = 10,
    parameter int LONG_CYC  = 20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_i,
    input  logic       dly_sel_i,
    input  logic       byte_req_i,
    output logic       busy_o,
    output logic       ready_o
);
    import sbm_pkg::*;

    localparam int MAX_CYC = (LONG_CYC > SHORT_CYC) ? LONG_CYC : SHORT_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             stx_prev;
    } tmr_st_t;

    tmr_st_t st_d, st_q;
    logic stx, start;

    always_comb begin
        stx   = (mode_i == MODE_STX);
        start = stx && (!st_q.stx_prev || byte_req_i);
        st_d  = st_q;
        st_d.stx_prev = stx;
        if (!stx) begin
            st_d.cnt = '0;
        end else if (start) begin
            st_d.cnt = dly_sel_i ? CNT_W'(LONG_CYC) : CNT_W'(SHORT_CYC);
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o  = (st_q.cnt != '0);
    assign ready_o = (st_q.cnt == CNT_W'(1));

    a_r9_ready_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |-> busy_o);

    a_r9_ready_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && !byte_req_i) |=> !busy_o);

    a_r10_leave_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i != MODE_STX) |=> !busy_o);
endmodule

// File: rtl/sbm_mode_ctrl.sv
module sbm_mode_ctrl #(
    parameter int ADDR_W    = 7,
    parameter int SHORT_CYC = 10,
    parameter int LONG_CYC  = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fmt_i2c_i,
    input  logic              wr_en_i,
    input  logic              wr_mst_i,
    input  logic              wr_trs_i,
    input  logic              wr_dly_sel_i,
    input  logic              frame_idle_i,
    input  logic              arb_lost_i,
    input  logic              overrun_i,
    input  logic              rx_byte_vld_i,
    input  logic [ADDR_W:0]   rx_byte_i,
    input  logic [ADDR_W-1:0] own_addr_i,
    input  logic              byte_req_i,
    output logic [1:0]        mode_o,
    output logic              clk_oe_o,
    output logic              setup_busy_o,
    output logic              setup_ready_o
);
    logic addr_hit;
    logic dly_sel;

    sbm_addr_match #(.ADDR_W(ADDR_W)) u_match (
        .fmt_i2c_i  (fmt_i2c_i),
        .mode_i     (mode_o),
        .vld_i      (rx_byte_vld_i),
        .byte_i     (rx_byte_i),
        .own_addr_i (own_addr_i),
        .hit_o      (addr_hit)
    );

    sbm_mode_reg u_mode (
        .clk          (clk),
        .rst_n        (rst_n),
        .fmt_i2c_i    (fmt_i2c_i),
        .wr_en_i      (wr_en_i),
        .wr_mst_i     (wr_mst_i),
        .wr_trs_i     (wr_trs_i),
        .wr_dly_sel_i (wr_dly_sel_i),
        .frame_idle_i (frame_idle_i),
        .arb_lost_i   (arb_lost_i),
        .overrun_i    (overrun_i),
        .addr_hit_i   (addr_hit),
        .mode_o       (mode_o),
        .dly_sel_o    (dly_sel)
    );

    sbm_setup_timer #(.SHORT_CYC(SHORT_CYC), .LONG_CYC(LONG_CYC)) u_tmr (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_i     (mode_o),
        .dly_sel_i  (dly_sel),
        .byte_req_i (byte_req_i),
        .busy_o     (setup_busy_o),
        .ready_o    (setup_ready_o)
    );

    assign clk_oe_o = !fmt_i2c_i && mode_o[1];

    a_r6_clk_oe_sync_only: assert property (@(posedge clk) disable iff (!rst_n)
        fmt_i2c_i |-> !clk_oe_o);
endmodule

// File: tb/sbm_mode_ctrl_tb.sv
module sbm_mode_ctrl_tb;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fmt_i2c = 1'b1, wr_en = 1'b0, wr_mst = 1'b0, wr_trs = 1'b0, wr_dly = 1'b0;
    logic frame_idle = 1'b1, arb_lost = 1'b0, overrun = 1'b0, rx_vld = 1'b0, byte_req = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic [6:0] own_addr = 7'h2A;
    logic [1:0] mode;
    logic clk_oe, busy, ready;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sbm_mode_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .fmt_i2c_i(fmt_i2c), .wr_en_i(wr_en),
        .wr_mst_i(wr_mst), .wr_trs_i(wr_trs), .wr_dly_sel_i(wr_dly),
        .frame_idle_i(frame_idle), .arb_lost_i(arb_lost), .overrun_i(overrun),
        .rx_byte_vld_i(rx_vld), .rx_byte_i(rx_byte), .own_addr_i(own_addr),
        .byte_req_i(byte_req), .mode_o(mode), .clk_oe_o(clk_oe),
        .setup_busy_o(busy), .setup_ready_o(ready)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [1:0] m, input logic sel);
        wr_en = 1'b1; wr_mst = m[1]; wr_trs = m[0]; wr_dly = sel;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // measure busy length and ready position from now on (busy sampled each tick)
    task automatic measure(input string req, input int exp_len, input bit count_now);
        int len = 0;
        int rdy_at = -1;
        int rdy_n = 0;
        if (count_now && busy) begin
            len = 1;
            if (ready) begin rdy_at = 1; rdy_n++; end
        end
        for (int i = 0; i < 40; i++) begin
            tick();
            if (busy) begin
                len++;
                if (ready) begin rdy_at = len; rdy_n++; end
            end else if (len > 0) begin
                break;
            end
        end
        chk({req, " busy length"}, len, exp_len);
        chk({req, " ready position"}, rdy_at, exp_len);
        chk({req, " ready count"}, rdy_n, 1);
    endtask

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 200000) begin
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual %0d expected below 200000", cyc);
                finish_run();
            end
        end
    end

    initial begin
        repeat (2) tick();
        // R1 reset state
        chk("R1 mode", mode, 0);
        chk("R1 clk_oe", clk_oe, 0);
        chk("R1 busy", busy, 0);
        chk("R1 ready", ready, 0);
        rst_n = 1'b1;
        tick();

        // R2 / R6: all writes under both formats
        for (int f = 0; f < 2; f++) begin
            for (int m = 0; m < 4; m++) begin
                fmt_i2c = f[0];
                wr(m[1:0], 1'b0);
                chk("R2 write mode", mode, m);
                chk("R6 clk_oe", clk_oe, (f == 0 && m >= 2) ? 1 : 0);
            end
        end

        // R3 arbitration loss and R5 overrun in every mode and format
        for (int f = 0; f < 2; f++) begin
            for (int m = 0; m < 4; m++) begin
                fmt_i2c = f[0];
                wr(m[1:0], 1'b0);
                arb_lost = 1'b1; tick(); arb_lost = 1'b0;
                chk("R3 arb loss", mode, (f == 1 && m >= 2) ? 0 : m);
                wr(m[1:0], 1'b0);
                overrun = 1'b1; tick(); overrun = 1'b0;
                chk("R5 overrun", mode, (f == 0 && m >= 2) ? 0 : m);
            end
        end

        // R4 address match: sweep every byte, own address 0x2A -> only 0x55 hits
        fmt_i2c = 1'b1;
        for (int b = 0; b < 256; b++) begin
            wr(2'b00, 1'b0);
            rx_byte = b[7:0]; rx_vld = 1'b1; tick(); rx_vld = 1'b0;
            chk("R4 address sweep", mode, (b == 8'h55) ? 1 : 0);
        end
        // R4 wrong format, wrong mode
        fmt_i2c = 1'b0;
        wr(2'b00, 1'b0);
        rx_byte = 8'h55; rx_vld = 1'b1; tick(); rx_vld = 1'b0;
        chk("R4 sync format ignored", mode, 0);
        fmt_i2c = 1'b1;
        wr(2'b10, 1'b0);
        rx_vld = 1'b1; tick(); rx_vld = 1'b0;
        chk("R4 master mode ignored", mode, 2);

        // R7 event beats same-cycle write
        wr(2'b11, 1'b0);
        arb_lost = 1'b1; wr(2'b01, 1'b1); arb_lost = 1'b0;
        chk("R7 arb over write", mode, 0);
        wr(2'b00, 1'b0);
        rx_vld = 1'b1; rx_byte = 8'h55; wr(2'b10, 1'b0); rx_vld = 1'b0;
        chk("R7 match over write", mode, 1);

        // R8 transmit bit deferred until frame idle
        wr(2'b00, 1'b0);
        frame_idle = 1'b0;
        wr(2'b11, 1'b0);
        chk("R8 master immediate", mode, 2);
        tick(); tick();
        chk("R8 transmit held", mode, 2);
        frame_idle = 1'b1;
        tick();
        chk("R8 applied at idle", mode, 3);

        // R9 setup delay lengths
        for (int s = 0; s < 2; s++) begin
            wr(2'b00, 1'b0);
            tick();
            wr(2'b01, s[0]);
            chk("R9 not busy on entry cycle", busy, 0);
            measure("R9", (s == 1) ? 20 : 10, 1'b0);
        end

        // R10 byte request reloads
        wr(2'b00, 1'b0);
        tick();
        wr(2'b01, 1'b0);
        repeat (6) tick();
        byte_req = 1'b1; tick(); byte_req = 1'b0;
        measure("R10 reload", 10, 1'b1);
        // R10 leaving slave transmit aborts
        wr(2'b00, 1'b0);
        tick();
        wr(2'b01, 1'b1);
        repeat (4) tick();
        chk("R10 busy before leave", busy, 1);
        wr(2'b10, 1'b1);
        tick();
        chk("R10 busy after leave", busy, 0);
        chk("R10 no ready after leave", ready, 0);

        done = 1;
        finish_run();
    end
endmodule